// File: doc/BRIEF.md
# Dual-Clock FIFO with Configurable Pointer Synchronizers

This block moves a stream of words from a write clock domain to an unrelated read clock domain. Each side has its own full flag, empty flag and used-word count, and each is timed only by its own clock. Writes and reads are accepted on the request input when the local flag allows it. A request against a full or empty queue is dropped, so the storage can never overflow or underflow.

The write and read pointers are one bit wider than the storage address. They are Gray-coded before they cross into the other domain through a flop chain. Each direction has its own depth setting. The setting uses an offset encoding: a setting of N gives N-2 flops, and any value below 3 is treated as 3. A setting of 4 (two flops) is the minimum for clocks that are truly unrelated. When both clocks are known to be aligned and integer multiples of each other, a locked-clocks parameter removes the chain, and each side reads the other side's pointer register directly.

A single asynchronous clear empties the queue. Two further options let each domain assert its own reset at once but release it only through two local flops. This keeps a request that is held high across the release from racing the first clock edge.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words leave the read port in exactly the order they were accepted at the write port, with none lost or repeated. `rdData` shows a word on the read-clock edge after the read request that took it is accepted.
- R2: On the write side, `wrUsed` never exceeds the depth (16 by default), `wrFull` is high only when `wrUsed` equals the depth, and `wrEmpty` is high when `wrUsed` is zero.
- R3: On the read side, `rdUsed` never exceeds the depth, `rdEmpty` is high only when `rdUsed` is zero, and `rdFull` is high when `rdUsed` equals the depth.
- R4: A write request while `wrFull` is high is dropped. The word is not stored, and `wrUsed` does not grow on the next write edge.
- R5: A read request while `rdEmpty` is high is dropped. `rdData` keeps its value and `rdUsed` stays at zero.
- R6: Each count moves by at most one word per local edge in its own direction. Once both sides have been idle longer than the synchronizer depth, both counts equal the true number of stored words.
- R7: While `clrAsync` is high, both sides report empty with zero counts and `rdData` is zero. After the clear, reading restarts with the first word written after it.
- R8: With `CLOCKS_LOCKED` set, a write accepted on an edge of a shared clock clears `rdEmpty` right after that same edge.
- R9: With `CLOCKS_LOCKED` clear and `W2R_SYNC` = 4 (two flops), a write accepted on edge k of a shared clock clears `rdEmpty` only after edge k+2.
- R10: With clear synchronization enabled, a domain stays in reset through the second local edge after `clrAsync` falls. A write request held high across the release is first accepted on the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| clrAsync | input | 1 | Asynchronous clear, active high |
| wrReq | input | 1 | Write request, timed by wrClk |
| wrData | input | DATA_W | Word to store |
| wrFull | output | 1 | Write-side full flag |
| wrEmpty | output | 1 | Write-side empty flag |
| wrUsed | output | ADDR_W+1 | Write-side stored-word count |
| rdReq | input | 1 | Read request, timed by rdClk |
| rdData | output | DATA_W | Registered read word |
| rdFull | output | 1 | Read-side full flag |
| rdEmpty | output | 1 | Read-side empty flag |
| rdUsed | output | ADDR_W+1 | Read-side stored-word count |

## Verification
The main instance runs on write and read clocks with unrelated periods, under four kinds of stimulus, each of which separates a different fault:
- A solid write burst past the depth, followed by reads past empty. This separates correct flag gating from overflow and underflow.
- Long random request streams on both sides, compared word for word against a bench queue. These expose pointer, Gray-code and ordering faults that only show up with concurrent traffic.
- A clear in the middle of traffic. This shows whether stale words survive the clear.
- Two extra instances that share one clock, one locked and one with two synchronizer flops. On these the edge-exact latency and the clear release can be measured, which tells the bypass apart from the flop chain.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Strobes the control hands to the datapath each edge.
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } dcfStrobes_t;

  // Offset-encoded synchronizer setting to real flop count.
  function automatic int syncStages(input int setting, input bit locked);
    if (locked) return 0;
    if (setting < 3) return 1;
    return setting - 2;
  endfunction

endpackage

// File: rtl/dcf_clr_sync.sv
module dcf_clr_sync #(
  parameter bit ENABLE = 1'b1,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clrAsync,
  output logic rstOut
);
  generate
    if (ENABLE) begin : g_sync
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or posedge clrAsync) begin
        if (clrAsync) chain <= '1;
        else          chain <= {chain[STAGES-2:0], 1'b0};
      end
      assign rstOut = chain[STAGES-1];
    end else begin : g_raw
      assign rstOut = clrAsync;
    end
  endgenerate
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= din;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign dout = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dcf_ctrl.sv
module dcf_ctrl
  import dcf_pkg::*;
#(
  parameter int AW            = 4,
  parameter int W2R_SYNC      = 4,
  parameter int R2W_SYNC      = 4,
  parameter bit CLOCKS_LOCKED = 1'b0,
  parameter bit WR_CLR_SYNC   = 1'b1,
  parameter bit RD_CLR_SYNC   = 1'b1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          clrAsync,
  input  logic          wrReq,
  input  logic          rdReq,
  output dcfStrobes_t   strb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrRst,
  output logic          rdRst,
  output logic          wrFull,
  output logic          wrEmpty,
  output logic [AW:0]   wrUsed,
  output logic          rdFull,
  output logic          rdEmpty,
  output logic [AW:0]   rdUsed
);
  localparam int PW        = AW + 1;
  localparam int DEPTH     = 1 << AW;
  localparam int W2R_FLOPS = syncStages(W2R_SYNC, CLOCKS_LOCKED);
  localparam int R2W_FLOPS = syncStages(R2W_SYNC, CLOCKS_LOCKED);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  dcf_clr_sync #(.ENABLE(WR_CLR_SYNC), .STAGES(2)) wrClr_i (
    .clk(wrClk), .clrAsync(clrAsync), .rstOut(wrRst));
  dcf_clr_sync #(.ENABLE(RD_CLR_SYNC), .STAGES(2)) rdClr_i (
    .clk(rdClk), .clrAsync(clrAsync), .rstOut(rdRst));

  // Write domain
  logic [PW-1:0] wrBin, wrGray, rdGrayAtWr, rdBinAtWr;
  logic          wrFire;

  assign wrFire = wrReq && !wrFull;

  always_ff @(posedge wrClk or posedge wrRst) begin
    if (wrRst) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrFire) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= toGray(wrBin + 1'b1);
    end
  end

  // Read domain
  logic [PW-1:0] rdBin, rdGray, wrGrayAtRd, wrBinAtRd;
  logic          rdFire;

  assign rdFire = rdReq && !rdEmpty;

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (rdFire) begin
      rdBin  <= rdBin + 1'b1;
      rdGray <= toGray(rdBin + 1'b1);
    end
  end

  // Crossings
  dcf_ptr_sync #(.W(PW), .STAGES(R2W_FLOPS)) r2w_i (
    .clk(wrClk), .rst(wrRst), .din(rdGray), .dout(rdGrayAtWr));
  dcf_ptr_sync #(.W(PW), .STAGES(W2R_FLOPS)) w2r_i (
    .clk(rdClk), .rst(rdRst), .din(wrGray), .dout(wrGrayAtRd));

  assign rdBinAtWr = fromGray(rdGrayAtWr);
  assign wrBinAtRd = fromGray(wrGrayAtRd);

  // Write-side status
  assign wrFull  = (wrGray == {~rdGrayAtWr[PW-1:PW-2], rdGrayAtWr[PW-3:0]});
  assign wrUsed  = wrBin - rdBinAtWr;
  assign wrEmpty = (wrUsed == '0);

  // Read-side status
  assign rdEmpty = (rdGray == wrGrayAtRd);
  assign rdUsed  = wrBinAtRd - rdBin;
  assign rdFull  = (rdUsed == PW'(DEPTH));

  assign strb.wrEn = wrFire;
  assign strb.rdEn = rdFire;
  assign wrAddr    = wrBin[AW-1:0];
  assign rdAddr    = rdBin[AW-1:0];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem
  import dcf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rdRst,
  input  dcfStrobes_t   strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrEn) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or posedge rdRst) begin
    if (rdRst)          rdData <= '0;
    else if (strb.rdEn) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 4,
  parameter int W2R_SYNC      = 4,
  parameter int R2W_SYNC      = 4,
  parameter bit CLOCKS_LOCKED = 1'b0,
  parameter bit WR_CLR_SYNC   = 1'b1,
  parameter bit RD_CLR_SYNC   = 1'b1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              clrAsync,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  output logic              wrEmpty,
  output logic [ADDR_W:0]   wrUsed,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFull,
  output logic              rdEmpty,
  output logic [ADDR_W:0]   rdUsed
);
  dcfStrobes_t       strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              wrRst, rdRst;

  dcf_ctrl #(
    .AW(ADDR_W), .W2R_SYNC(W2R_SYNC), .R2W_SYNC(R2W_SYNC),
    .CLOCKS_LOCKED(CLOCKS_LOCKED),
    .WR_CLR_SYNC(WR_CLR_SYNC), .RD_CLR_SYNC(RD_CLR_SYNC)
  ) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .clrAsync(clrAsync),
    .wrReq(wrReq), .rdReq(rdReq), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrRst(wrRst), .rdRst(rdRst),
    .wrFull(wrFull), .wrEmpty(wrEmpty), .wrUsed(wrUsed),
    .rdFull(rdFull), .rdEmpty(rdEmpty), .rdUsed(rdUsed)
  );

  dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) mem_i (
    .wrClk(wrClk), .rdClk(rdClk), .rdRst(rdRst), .strb(strb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          wrRst,
  input logic          rdRst,
  input logic          wrReq,
  input logic          rdReq,
  input logic          wrFull,
  input logic          wrEmpty,
  input logic [AW:0]   wrUsed,
  input logic          rdFull,
  input logic          rdEmpty,
  input logic [AW:0]   rdUsed,
  input logic [DW-1:0] rdData
);
  localparam int UW = AW + 1;
  localparam logic [UW:0] DEPTH_X = (UW+1)'(1 << AW);

  // R2
  a_r2_full_at_depth: assert property (@(posedge wrClk) disable iff (wrRst)
    wrFull |-> ({1'b0, wrUsed} == DEPTH_X));
  a_r2_used_bounded: assert property (@(posedge wrClk) disable iff (wrRst)
    {1'b0, wrUsed} <= DEPTH_X);
  a_r2_empty_at_zero: assert property (@(posedge wrClk) disable iff (wrRst)
    wrEmpty |-> !wrFull);

  // R3
  a_r3_empty_at_zero: assert property (@(posedge rdClk) disable iff (rdRst)
    rdEmpty |-> (rdUsed == '0));
  a_r3_used_bounded: assert property (@(posedge rdClk) disable iff (rdRst)
    {1'b0, rdUsed} <= DEPTH_X);
  a_r3_full_not_empty: assert property (@(posedge rdClk) disable iff (rdRst)
    rdFull |-> !rdEmpty);

  // R4
  a_r4_no_overflow: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrFull && wrReq) |=> (wrUsed <= $past(wrUsed)));

  // R5
  a_r5_no_underflow: assert property (@(posedge rdClk) disable iff (rdRst)
    (rdEmpty && rdReq) |=> $stable(rdData));

  // R6
  a_r6_wr_step: assert property (@(posedge wrClk) disable iff (wrRst)
    {1'b0, wrUsed} <= ({1'b0, $past(wrUsed)} + 1'b1));
  a_r6_rd_step: assert property (@(posedge rdClk) disable iff (rdRst)
    ({1'b0, rdUsed} + 1'b1) >= {1'b0, $past(rdUsed)});
endmodule

bind dual_clock_fifo dcf_checker #(.DW(DATA_W), .AW(ADDR_W)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .wrRst(wrRst), .rdRst(rdRst),
  .wrReq(wrReq), .rdReq(rdReq), .wrFull(wrFull), .wrEmpty(wrEmpty),
  .wrUsed(wrUsed), .rdFull(rdFull), .rdEmpty(rdEmpty), .rdUsed(rdUsed),
  .rdData(rdData)
);

// File: tb/dual_clock_fifo_tb_top.sv
`timescale 1ns/1ps
module dual_clock_fifo_tb_top;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic wrClk = 1'b0, rdClk = 1'b0, clkB = 1'b0;
  always #2.5 wrClk = ~wrClk;
  always #3.7 rdClk = ~rdClk;
  always #2.5 clkB  = ~clkB;

  // Main instance, unrelated clocks
  logic          clr = 1'b1;
  logic          wrReq = 1'b0, rdReq = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic          wrFull, wrEmpty, rdFull, rdEmpty;
  logic [AW:0]   wrUsed, rdUsed;
  logic [DW-1:0] rdData;

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .clrAsync(clr),
    .wrReq(wrReq), .wrData(wrData), .wrFull(wrFull), .wrEmpty(wrEmpty),
    .wrUsed(wrUsed), .rdReq(rdReq), .rdData(rdData), .rdFull(rdFull),
    .rdEmpty(rdEmpty), .rdUsed(rdUsed));

  // Shared-clock instances: locked and two-flop
  logic          clrB = 1'b1, bWrReq = 1'b0, bRdReq = 1'b0;
  logic [DW-1:0] bWrData = 8'h5A;
  logic          lkWrFull, lkWrEmpty, lkRdFull, lkRdEmpty;
  logic [AW:0]   lkWrUsed, lkRdUsed;
  logic [DW-1:0] lkRdData;
  logic          slWrFull, slWrEmpty, slRdFull, slRdEmpty;
  logic [AW:0]   slWrUsed, slRdUsed;
  logic [DW-1:0] slRdData;

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .CLOCKS_LOCKED(1'b1)) dutLock_i (
    .wrClk(clkB), .rdClk(clkB), .clrAsync(clrB),
    .wrReq(bWrReq), .wrData(bWrData), .wrFull(lkWrFull), .wrEmpty(lkWrEmpty),
    .wrUsed(lkWrUsed), .rdReq(bRdReq), .rdData(lkRdData), .rdFull(lkRdFull),
    .rdEmpty(lkRdEmpty), .rdUsed(lkRdUsed));

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .W2R_SYNC(4)) dutSlow_i (
    .wrClk(clkB), .rdClk(clkB), .clrAsync(clrB),
    .wrReq(bWrReq), .wrData(bWrData), .wrFull(slWrFull), .wrEmpty(slWrEmpty),
    .wrUsed(slWrUsed), .rdReq(bRdReq), .rdData(slRdData), .rdFull(slRdFull),
    .rdEmpty(slRdEmpty), .rdUsed(slRdUsed));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Writes until n words accepted; pct is request probability.
  task automatic wrBurst(input int n, input int pct);
    int acc = 0;
    while (acc < n) begin
      @(negedge wrClk);
      wrReq  = ($urandom % 100) < pct;
      wrData = DW'($urandom);
      if (wrReq && !wrFull) begin
        q.push_back(wrData);
        acc++;
      end
    end
    @(negedge wrClk);
    wrReq = 1'b0;
  endtask

  // Holds write request for n cycles regardless of full.
  task automatic wrForce(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrReq  = 1'b1;
      wrData = DW'($urandom);
      if (!wrFull) q.push_back(wrData);
    end
    @(negedge wrClk);
    wrReq = 1'b0;
  endtask

  // Reads n words, comparing against the queue.
  task automatic rdBurst(input int n, input int pct, input string req);
    int  got = 0;
    bit  pend = 1'b0;
    while (got < n) begin
      @(negedge rdClk);
      if (pend) begin
        logic [DW-1:0] exp;
        exp = (q.size() > 0) ? q.pop_front() : '0;
        check(rdData == exp, req, rdData, exp);
        got++;
        pend = 1'b0;
      end
      if (got < n) begin
        rdReq = ($urandom % 100) < pct;
        pend  = rdReq && !rdEmpty;
      end else begin
        rdReq = 1'b0;
      end
    end
    rdReq = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge wrClk);
    repeat (8) @(negedge rdClk);
  endtask

  initial begin
    #900000;
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  // Shared-clock instances: R10, R8, R9
  initial begin
    bWrReq = 1'b1;
    repeat (3) @(negedge clkB);
    clrB = 1'b0;
    @(negedge clkB);  // after e1
    check(slWrUsed == 0, "R10 e1", slWrUsed, 0);
    @(negedge clkB);  // after e2
    check(slWrUsed == 0, "R10 e2", slWrUsed, 0);
    check(lkWrUsed == 0, "R10 e2 locked", lkWrUsed, 0);
    @(negedge clkB);  // after e3, write accepted on e3
    bWrReq = 1'b0;
    check(slWrUsed == 1, "R10 e3", slWrUsed, 1);
    check(lkRdEmpty == 0, "R8 locked rdEmpty", lkRdEmpty, 0);
    check(lkRdUsed == 1, "R8 locked rdUsed", lkRdUsed, 1);
    check(slRdEmpty == 1, "R9 k+0", slRdEmpty, 1);
    @(negedge clkB);
    check(slRdEmpty == 1, "R9 k+1", slRdEmpty, 1);
    @(negedge clkB);
    check(slRdEmpty == 0, "R9 k+2", slRdEmpty, 0);
    check(slRdUsed == 1, "R9 k+2 used", slRdUsed, 1);
  end

  // Main instance
  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge wrClk);
    // R7: state during clear
    check(wrEmpty == 1 && rdEmpty == 1, "R7 clear empty", {wrEmpty, rdEmpty}, 3);
    check(wrUsed == 0 && rdUsed == 0, "R7 clear used", wrUsed + rdUsed, 0);
    check(rdData == 0, "R7 clear rdData", rdData, 0);
    check(wrFull == 0 && rdFull == 0, "R2 R3 not full at clear", {wrFull, rdFull}, 0);
    @(negedge wrClk);
    clr = 1'b0;
    settle();

    // R4: overflow attempt, R2/R3 full flags
    wrForce(DEPTH + 3);
    check(q.size() == DEPTH, "R4 accepted count", q.size(), DEPTH);
    check(wrFull == 1, "R2 wrFull", wrFull, 1);
    check(wrUsed == DEPTH, "R2 wrUsed full", wrUsed, DEPTH);
    settle();
    check(rdFull == 1, "R3 rdFull", rdFull, 1);
    check(rdUsed == DEPTH, "R3 rdUsed full", rdUsed, DEPTH);

    // R1: drain in order, extra words absent
    rdBurst(DEPTH, 100, "R1 R4 drain order");

    // R5: underflow attempt
    begin
      logic [DW-1:0] hold;
      @(negedge rdClk);
      hold = rdData;
      rdReq = 1'b1;
      repeat (4) @(negedge rdClk);
      rdReq = 1'b0;
      check(rdData == hold, "R5 rdData kept", rdData, hold);
      check(rdUsed == 0 && rdEmpty == 1, "R5 still empty", rdUsed, 0);
    end
    settle();
    check(wrEmpty == 1 && wrUsed == 0, "R2 wrEmpty", wrUsed, 0);

    // R6: settled counts equal occupancy
    wrBurst(5, 100);
    settle();
    check(wrUsed == 5, "R6 wrUsed settled", wrUsed, 5);
    check(rdUsed == 5, "R6 rdUsed settled", rdUsed, 5);
    rdBurst(5, 100, "R1 short");

    // R1: concurrent random streams, several rate mixes
    fork
      wrBurst(600, 70);
      rdBurst(600, 40, "R1 fast writer");
    join
    fork
      wrBurst(600, 30);
      rdBurst(600, 90, "R1 fast reader");
    join
    fork
      wrBurst(400, 100);
      rdBurst(400, 100, "R1 both saturated");
    join
    settle();
    check(wrUsed == 0 && rdUsed == 0, "R6 idle after streams", wrUsed + rdUsed, 0);

    // R7: clear with data stored
    wrBurst(7, 100);
    settle();
    clr = 1'b1;
    q.delete();
    repeat (3) @(negedge wrClk);
    check(rdEmpty == 1 && rdUsed == 0, "R7 clear drops data", rdUsed, 0);
    check(wrEmpty == 1 && wrUsed == 0, "R7 clear wr side", wrUsed, 0);
    clr = 1'b0;
    settle();
    wrBurst(3, 100);
    settle();
    rdBurst(3, 100, "R7 restart order");

    finishRun();
  end
endmodule